// File: doc/BRIEF.md
# Burst Address Counter Register

This block produces the internal address for one port of a synchronous memory. On every rising clock edge it picks one of four actions: clear the address to zero, take the external address bus, step the previous internal address up by one, or keep the previous address. The chosen value goes into a register. The memory access of that cycle uses the register output, so the new address needs no extra cycle before it can be used.

An external master can start a burst with a single address strobe and then clock through consecutive words by holding the count enable low. It can pause the burst by releasing the count enable, or jump back to word zero with the counter-reset input. A read or write may happen in the same cycle as a counter reset, and that access goes to address zero. The counter controls act on their own. They do not depend on chip enables, byte enables or the read/write line, so none of those signals enter this block.

The address width is a parameter. The default of 15 bits covers a 32K-word array, and 14 bits suits a 16K-word array.

Top module: `burst_addr_counter`

## Requirements
- R1: When `clear_n` is sampled low on a rising edge, `int_addr` is 0 after that edge, whatever `strobe_n`, `count_n` and `ext_addr` are.
- R2: When `clear_n` is high and `strobe_n` is low, `int_addr` equals the sampled `ext_addr` after that edge.
- R3: When `clear_n` and `strobe_n` are high and `count_n` is low, `int_addr` becomes its previous value plus one after that edge.
- R4: Stepping from the all-ones address (0x7FFF at the default width) gives 0.
- R5: When `clear_n`, `strobe_n` and `count_n` are all high, `int_addr` keeps its value and changes on `ext_addr` are ignored.
- R6: Inputs are sampled only at the rising clock edge. Changes to any input between edges leave `int_addr` unchanged until the next edge.
- R7: A high `rst` sampled on a rising edge forces `int_addr` to 0 after that edge, overriding every other input.
- R8: When `strobe_n` and `count_n` are both low with `clear_n` high, the load wins: `int_addr` equals `ext_addr`, not the stepped value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous system reset, active high |
| ext_addr | input | ADDR_W | External address bus |
| strobe_n | input | 1 | Address load strobe, active low |
| count_n | input | 1 | Count enable, active low |
| clear_n | input | 1 | Counter reset to zero, active low |
| int_addr | output | ADDR_W | Registered internal address used for this cycle's access |

## Verification
A wrong action choice or a bad stepped value shows on `int_addr` right after the edge that made it. From then on, every later step or hold carries the error forward until the next load or clear. The bench therefore compares the port against a behavioural model after every edge. The checks include priority collisions between clear, load and step, wrap at the top address, and input changes placed between edges.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Action chosen for the next internal address
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2,
        ACT_ZERO = 2'd3
    } addr_act_e;

    // Sampled counter controls, all active low
    typedef struct packed {
        logic clear_n;
        logic strobe_n;
        logic count_n;
    } addr_ctl_t;

    // Fixed priority: clear, then load, then step, else hold
    function automatic addr_act_e pick_action(addr_ctl_t c);
        if (!c.clear_n)       return ACT_ZERO;
        else if (!c.strobe_n) return ACT_LOAD;
        else if (!c.count_n)  return ACT_STEP;
        else                  return ACT_HOLD;
    endfunction

endpackage

// File: rtl/bac_ctl_decode.sv
module bac_ctl_decode
    import burst_addr_pkg::*;
(
    input  addr_ctl_t ctl,
    output addr_act_e act
);
    always_comb begin
        act = pick_action(ctl);
    end
endmodule

// File: rtl/bac_step.sv
module bac_step #(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt
);
    // Plain modular increment; the carry out of the top bit is dropped
    always_comb begin
        nxt = cur + ADDR_W'(1);
    end
endmodule

// File: rtl/bac_addr_reg.sv
module bac_addr_reg
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  addr_act_e         act,
    input  logic [ADDR_W-1:0] load_val,
    input  logic [ADDR_W-1:0] step_val,
    output logic [ADDR_W-1:0] q
);
    logic [ADDR_W-1:0] d;

    always_comb begin
        unique case (act)
            ACT_ZERO: d = '0;
            ACT_LOAD: d = load_val;
            ACT_STEP: d = step_val;
            default:  d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              count_n,
    input  logic              clear_n,
    output logic [ADDR_W-1:0] int_addr
);
    addr_ctl_t         ctl;
    addr_act_e         act;
    logic [ADDR_W-1:0] stepped;

    assign ctl = '{clear_n: clear_n, strobe_n: strobe_n, count_n: count_n};

    bac_ctl_decode u_decode (
        .ctl (ctl),
        .act (act)
    );

    bac_step #(.ADDR_W(ADDR_W)) u_step (
        .cur (int_addr),
        .nxt (stepped)
    );

    bac_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .load_val (ext_addr),
        .step_val (stepped),
        .q        (int_addr)
    );
endmodule

// File: rtl/burst_addr_counter_chk.sv
module burst_addr_counter_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              strobe_n,
    input logic              count_n,
    input logic              clear_n,
    input logic [ADDR_W-1:0] int_addr
);
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> int_addr == '0); // R1

    AST_LOAD_EXT: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !strobe_n) |=> int_addr == $past(ext_addr)); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (clear_n && strobe_n && !count_n) |=> int_addr == ADDR_W'($past(int_addr) + ADDR_W'(1))); // R3

    AST_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
        (clear_n && strobe_n && !count_n && (&int_addr)) |=> int_addr == '0); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (clear_n && strobe_n && count_n) |=> $stable(int_addr)); // R5

    AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !strobe_n && !count_n) |=> int_addr == $past(ext_addr)); // R8

    AST_SYS_RESET: assert property (@(posedge clk)
        rst |=> int_addr == '0); // R7
endmodule

bind burst_addr_counter burst_addr_counter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_addr (ext_addr),
    .strobe_n (strobe_n),
    .count_n  (count_n),
    .clear_n  (clear_n),
    .int_addr (int_addr)
);

// File: tb/burst_addr_counter_tb.sv
module burst_addr_counter_tb;
    localparam int AW   = 15;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_n = 1'b1;
    logic          count_n  = 1'b1;
    logic          clear_n  = 1'b1;
    logic [AW-1:0] int_addr;

    int  n_vec = 0;
    int  n_bad = 0;
    int  mdl   = 0;
    bit  done  = 0;

    always #10 clk = ~clk; // 50 MHz

    burst_addr_counter #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .ext_addr(ext_addr), .strobe_n(strobe_n),
        .count_n(count_n), .clear_n(clear_n), .int_addr(int_addr)
    );

    task automatic check(input string req, input int exp);
        n_vec++;
        if (int_addr !== AW'(exp)) begin
            n_bad++;
            $display("FAIL %s: int_addr=%h expected %h", req, int_addr, AW'(exp));
        end
    endtask

    // One clock: drive at falling edge, model the rising edge, compare after it.
    // With wiggle set, inputs are disturbed mid-cycle and the output must stay (R6).
    task automatic step(input logic cl, input logic st, input logic cn,
                        input int ea, input bit wiggle);
        string tag;
        @(negedge clk);
        clear_n = cl; strobe_n = st; count_n = cn; ext_addr = AW'(ea);
        @(posedge clk);
        if (!cl)             begin tag = "R1"; mdl = 0; end
        else if (!st)        begin tag = cn ? "R2" : "R8"; mdl = ea & MASK; end
        else if (!cn)        begin tag = (mdl == MASK) ? "R4" : "R3"; mdl = (mdl + 1) & MASK; end
        else                 tag = "R5";
        #2;
        check(tag, mdl);
        if (wiggle) begin
            #3;
            strobe_n = 1'b0; clear_n = 1'b0; count_n = 1'b0;
            ext_addr = AW'($urandom);
            #3;
            check("R6", mdl);
        end
    endtask

    task automatic sys_reset();
        @(negedge clk);
        rst = 1'b1; strobe_n = 1'b0; count_n = 1'b0; ext_addr = AW'(16'h1234);
        @(posedge clk);
        #2;
        mdl = 0;
        check("R7", 0);
        @(negedge clk);
        rst = 1'b0; strobe_n = 1'b1; count_n = 1'b1; clear_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R7", 0);                 // reset state
        @(negedge clk);
        rst = 1'b0;

        // R2 load, R3 steps
        step(1, 0, 1, 16'h0100, 0);
        step(1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        // R5 hold while the external bus moves
        step(1, 1, 1, 16'h5555, 0);
        step(1, 1, 1, 16'h2AAA, 0);
        // R4 wrap at the top address
        step(1, 0, 1, MASK - 1, 0);
        step(1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        // R8 load wins over step
        step(1, 0, 0, 16'h0ABC, 0);
        // R1 clear wins over load and step
        step(0, 0, 0, 16'h7777, 0);
        step(1, 0, 1, 16'h0042, 0);
        step(0, 1, 1, 16'h0042, 0);
        // R6 mid-cycle disturbance
        step(1, 0, 1, 16'h1111, 1);
        step(1, 1, 0, 0, 1);
        step(1, 1, 1, 0, 1);
        // R7 reset mid-run, over a pending load
        step(1, 0, 1, 16'h3333, 0);
        sys_reset();

        // Mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 15);
            step(r != 0, r > 3 && r < 6 ? 1'b0 : (r == 1 ? 1'b0 : 1'b1),
                 r < 12 ? 1'b0 : 1'b1,
                 (r == 5) ? MASK - $urandom_range(0, 2) : int'($urandom & MASK),
                 (i % 97) == 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule